// File: doc/BRIEF.md
# Pipelined Burst SRAM Control Core

This block models the control path of a synchronous, pipelined burst memory, backed by a small internal array. Every control and data input is sampled on the rising clock edge. An access begins when one of two address strobes is asserted while the chip enable is low. One strobe serves a processor and always starts a read. The other serves a memory controller and can start either a read or a write.

After the first beat, the address comes from a two-bit burst counter. The counter steps only while the advance input is low. It combines with the starting address in linear or interleaved order, chosen by a mode input. Writes go through per-lane byte masks, or through a global write that covers every lane.

Read data passes through an output register. The drive enable for the shared data bus is dropped whenever a write is in flight, after a deselect, or while the output enable is high. The bus is released again only by a read that a strobe starts.

Top module: `burst_sram_core`

## Requirements
- R1: With `cs_n_i` low, a low `strb_cpu_n_i` or `strb_ctl_n_i` loads `addr_i` as the burst base and clears the beat count. A start from the processor strobe is always a read and ignores every write control. When both strobes are low, the processor strobe wins.
- R2: In a cycle with no strobe during an active burst, `adv_n_i` low steps the beat count by one. `adv_n_i` high holds the count, so the same address is accessed again.
- R3: With `mode_i` low at the start, beat n uses address bits [1:0] equal to (base[1:0] + n) mod 4. All higher address bits stay equal to the base.
- R4: With `mode_i` high at the start, beat n uses address bits [1:0] equal to base[1:0] XOR n. All higher address bits stay equal to the base.
- R5: After four advances, the burst returns to its starting address.
- R6: A low `strb_ctl_n_i` during a running burst discards that burst and restarts from the new `addr_i` at beat 0.
- R7: `wr_all_n_i` low writes all four byte lanes of `wdata_i`, whatever `byte_sel_n_i` and `wr_en_n_i` hold. Lane i is bits [8i+7:8i].
- R8: With `wr_all_n_i` high and `wr_en_n_i` low, only lanes i with `byte_sel_n_i[i]` low are written. With both `wr_all_n_i` and `wr_en_n_i` high, the cycle is a read and memory is unchanged.
- R9: For a read whose address is registered at clock edge k, the data is on `rdata_o` with `rdata_oe_o` high after edge k+1.
- R10: `rdata_oe_o` is low for the whole cycle that follows an edge registering a write, whatever `oe_n_i` holds. After a write it stays low through strobe-less beats until a read started by a strobe.
- R11: `oe_n_i` high forces `rdata_oe_o` low at once, without waiting for a clock edge.
- R12: A strobe sampled while `cs_n_i` is high ends the burst. `rdata_oe_o` is then low after the second edge, and advance pulses have no effect until the next start. After reset `rdata_oe_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_i | input | ADDR_W | Word address, loaded at a start |
| cs_n_i | input | 1 | Chip enable, active low |
| strb_cpu_n_i | input | 1 | Processor address strobe, active low, read-only start |
| strb_ctl_n_i | input | 1 | Controller address strobe, active low |
| adv_n_i | input | 1 | Burst advance, active low |
| mode_i | input | 1 | Burst order: 0 linear, 1 interleaved |
| wr_all_n_i | input | 1 | Global write, active low |
| wr_en_n_i | input | 1 | Byte-write enable, active low |
| byte_sel_n_i | input | BYTES | Per-lane write select, active low |
| wdata_i | input | BYTES*BYTE_W | Write data |
| oe_n_i | input | 1 | Asynchronous output enable, active low |
| rdata_o | output | BYTES*BYTE_W | Registered read data |
| rdata_oe_o | output | 1 | Data bus drive enable |

## Verification
The assertions check four things on every clock:
- a processor-strobe start loads the base and clears the count as a read;
- a suspended beat keeps the counter still;
- a controller-strobe global write keeps the bus undriven in the next cycle;
- a deselect leaves the bus undriven two edges later.

Only the bench scenarios can show the rest. That covers the actual addresses visited in linear and interleaved order from every start offset, the wrap after four beats, and the restart on a controller strobe. It also covers the merged contents left by masked and global writes, and the rule that the bus stays quiet after a write until a strobe-started read.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

    // Width of the beat counter: four beats per burst.
    localparam int unsigned BURST_BITS = 2;

    typedef enum logic [1:0] {
        CMD_HOLD      = 2'd0,   // no strobe: continue or stay idle
        CMD_START_CPU = 2'd1,   // processor strobe start (read only)
        CMD_START_CTL = 2'd2,   // controller strobe start (read or write)
        CMD_DESEL     = 2'd3    // strobe with chip disabled
    } cmd_e;

endpackage

// File: rtl/burst_sram_decode.sv
module burst_sram_decode
    import burst_sram_pkg::*;
#(
    parameter int unsigned BYTES = 4
) (
    input  logic             cs_n_i,
    input  logic             strb_cpu_n_i,
    input  logic             strb_ctl_n_i,
    input  logic             wr_all_n_i,
    input  logic             wr_en_n_i,
    input  logic [BYTES-1:0] byte_sel_n_i,
    output cmd_e             cmd_o,
    output logic [BYTES-1:0] wr_mask_o,
    output logic             wr_req_o
);

    always_comb begin
        // Global write overrides the lane selects.
        if (!wr_all_n_i) begin
            wr_mask_o = '1;
        end else if (!wr_en_n_i) begin
            wr_mask_o = ~byte_sel_n_i;
        end else begin
            wr_mask_o = '0;
        end
        wr_req_o = |wr_mask_o;

        if (!strb_cpu_n_i || !strb_ctl_n_i) begin
            if (cs_n_i) begin
                cmd_o = CMD_DESEL;
            end else if (!strb_cpu_n_i) begin
                cmd_o = CMD_START_CPU;
            end else begin
                cmd_o = CMD_START_CTL;
            end
        end else begin
            cmd_o = CMD_HOLD;
        end
    end

endmodule

// File: rtl/burst_sram_seq.sv
module burst_sram_seq
    import burst_sram_pkg::*;
#(
    parameter int unsigned ADDR_W = 6
) (
    input  logic [ADDR_W-1:0]     base_i,
    input  logic [BURST_BITS-1:0] beat_i,
    input  logic                  ilv_i,
    output logic [ADDR_W-1:0]     addr_o
);

    logic [BURST_BITS-1:0] lo;

    always_comb begin
        if (ilv_i) begin
            lo = base_i[BURST_BITS-1:0] ^ beat_i;
        end else begin
            lo = base_i[BURST_BITS-1:0] + beat_i;
        end
        addr_o = {base_i[ADDR_W-1:BURST_BITS], lo};
    end

endmodule

// File: rtl/burst_sram_array.sv
module burst_sram_array #(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned BYTES  = 4,
    parameter int unsigned BYTE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we_i,
    input  logic                    re_i,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic [BYTES*BYTE_W-1:0] wdata_i,
    input  logic [BYTES-1:0]        wmask_i,
    output logic [BYTES*BYTE_W-1:0] rdata_o
);

    localparam int unsigned DEPTH = 1 << ADDR_W;

    // One storage column per byte lane, each with its own output register.
    for (genvar b = 0; b < BYTES; b++) begin : g_lane
        logic [BYTE_W-1:0] lane_mem [DEPTH];
        logic [BYTE_W-1:0] lane_q;

        always_ff @(posedge clk) begin
            if (we_i && wmask_i[b]) begin
                lane_mem[addr_i] <= wdata_i[b*BYTE_W +: BYTE_W];
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lane_q <= '0;
            end else if (re_i) begin
                lane_q <= lane_mem[addr_i];
            end
        end

        assign rdata_o[b*BYTE_W +: BYTE_W] = lane_q;
    end

endmodule

// File: rtl/burst_sram_core.sv
module burst_sram_core
    import burst_sram_pkg::*;
#(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned BYTES  = 4,
    parameter int unsigned BYTE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic                    cs_n_i,
    input  logic                    strb_cpu_n_i,
    input  logic                    strb_ctl_n_i,
    input  logic                    adv_n_i,
    input  logic                    mode_i,
    input  logic                    wr_all_n_i,
    input  logic                    wr_en_n_i,
    input  logic [BYTES-1:0]        byte_sel_n_i,
    input  logic [BYTES*BYTE_W-1:0] wdata_i,
    input  logic                    oe_n_i,
    output logic [BYTES*BYTE_W-1:0] rdata_o,
    output logic                    rdata_oe_o
);

    localparam int unsigned DATA_W = BYTES * BYTE_W;

    typedef struct packed {
        logic                  active;   // burst in progress
        logic                  ilv;      // order latched at start
        logic [ADDR_W-1:0]     base;
        logic [BURST_BITS-1:0] cnt;
        logic                  rd_ok;    // bus may be driven by reads
        logic                  op_vld;   // registered access stage
        logic                  op_wr;
        logic                  op_show;
        logic [ADDR_W-1:0]     op_addr;
        logic [DATA_W-1:0]     op_data;
        logic [BYTES-1:0]      op_mask;
        logic                  out_en;   // output register holds shown data
    } state_t;

    state_t s_d, s_q;

    cmd_e                  cmd;
    logic [BYTES-1:0]      wr_mask;
    logic                  wr_req;
    logic [BURST_BITS-1:0] cnt_step;
    logic [ADDR_W-1:0]     beat_addr;

    burst_sram_decode #(.BYTES(BYTES)) u_decode (
        .cs_n_i      (cs_n_i),
        .strb_cpu_n_i(strb_cpu_n_i),
        .strb_ctl_n_i(strb_ctl_n_i),
        .wr_all_n_i  (wr_all_n_i),
        .wr_en_n_i   (wr_en_n_i),
        .byte_sel_n_i(byte_sel_n_i),
        .cmd_o       (cmd),
        .wr_mask_o   (wr_mask),
        .wr_req_o    (wr_req)
    );

    assign cnt_step = s_q.cnt + {{(BURST_BITS-1){1'b0}}, ~adv_n_i};

    burst_sram_seq #(.ADDR_W(ADDR_W)) u_seq (
        .base_i(s_q.base),
        .beat_i(cnt_step),
        .ilv_i (s_q.ilv),
        .addr_o(beat_addr)
    );

    always_comb begin
        s_d         = s_q;
        s_d.op_vld  = 1'b0;
        s_d.op_wr   = 1'b0;
        s_d.op_show = 1'b0;
        s_d.op_mask = '0;
        s_d.out_en  = s_q.op_vld && !s_q.op_wr && s_q.op_show;
        unique case (cmd)
            CMD_START_CPU: begin
                s_d.active  = 1'b1;
                s_d.ilv     = mode_i;
                s_d.base    = addr_i;
                s_d.cnt     = '0;
                s_d.rd_ok   = 1'b1;
                s_d.op_vld  = 1'b1;
                s_d.op_addr = addr_i;
                s_d.op_show = 1'b1;
            end
            CMD_START_CTL: begin
                s_d.active  = 1'b1;
                s_d.ilv     = mode_i;
                s_d.base    = addr_i;
                s_d.cnt     = '0;
                s_d.rd_ok   = !wr_req;
                s_d.op_vld  = 1'b1;
                s_d.op_wr   = wr_req;
                s_d.op_addr = addr_i;
                s_d.op_data = wdata_i;
                s_d.op_mask = wr_mask;
                s_d.op_show = !wr_req;
            end
            CMD_DESEL: begin
                s_d.active = 1'b0;
                s_d.rd_ok  = 1'b0;
            end
            default: begin
                if (s_q.active) begin
                    s_d.cnt     = cnt_step;
                    s_d.op_vld  = 1'b1;
                    s_d.op_wr   = wr_req;
                    s_d.op_addr = beat_addr;
                    s_d.op_data = wdata_i;
                    s_d.op_mask = wr_mask;
                    s_d.op_show = !wr_req && s_q.rd_ok;
                    if (wr_req) begin
                        s_d.rd_ok = 1'b0;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    burst_sram_array #(
        .ADDR_W(ADDR_W),
        .BYTES (BYTES),
        .BYTE_W(BYTE_W)
    ) u_array (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (s_q.op_vld && s_q.op_wr),
        .re_i   (s_q.op_vld && !s_q.op_wr),
        .addr_i (s_q.op_addr),
        .wdata_i(s_q.op_data),
        .wmask_i(s_q.op_mask),
        .rdata_o(rdata_o)
    );

    // Bus drive: data shown, output enabled, no write currently in flight.
    assign rdata_oe_o = s_q.out_en && !oe_n_i && !(s_q.op_vld && s_q.op_wr);

    // R1: processor strobe start loads base, clears count, never writes
    a_r1_cpu_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (!strb_cpu_n_i && !cs_n_i) |=>
            (s_q.active && s_q.cnt == '0 && s_q.base == $past(addr_i) && !s_q.op_wr));

    // R2: a suspended beat keeps the counter still
    a_r2_suspend_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.active && strb_cpu_n_i && strb_ctl_n_i && !adv_n_i == 1'b0) |=> $stable(s_q.cnt));

    // R10: controller-strobe global write leaves the bus undriven next cycle
    a_r10_quiet_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!strb_ctl_n_i && strb_cpu_n_i && !cs_n_i && !wr_all_n_i) |=> !rdata_oe_o);

    // R12: deselect turns the bus off two edges later
    a_r12_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((!strb_cpu_n_i || !strb_ctl_n_i) && cs_n_i) |-> ##2 !rdata_oe_o);

endmodule

// File: tb/burst_sram_core_test.sv
`timescale 1ns/1ps
module burst_sram_core_test;

    localparam int AW = 6;
    localparam int NB = 4;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          cs_n = 1'b0;
    logic          cpu_n = 1'b1;
    logic          ctl_n = 1'b1;
    logic          adv_n = 1'b1;
    logic          mode = 1'b0;
    logic          wall_n = 1'b1;
    logic          wen_n = 1'b1;
    logic [NB-1:0] bsel_n = '1;
    logic [DW-1:0] wdata = '0;
    logic          oe_n = 1'b0;
    logic [DW-1:0] rdata;
    logic          rdata_oe;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    logic [DW-1:0] shadow [64];

    burst_sram_core #(.ADDR_W(AW), .BYTES(NB), .BYTE_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .cs_n_i(cs_n),
        .strb_cpu_n_i(cpu_n), .strb_ctl_n_i(ctl_n), .adv_n_i(adv_n),
        .mode_i(mode), .wr_all_n_i(wall_n), .wr_en_n_i(wen_n),
        .byte_sel_n_i(bsel_n), .wdata_i(wdata), .oe_n_i(oe_n),
        .rdata_o(rdata), .rdata_oe_o(rdata_oe)
    );

    always #2 clk = ~clk;

    initial begin
        #400000;
        if (!done) begin
            fails++;
            $display("FAIL all requirements (watchdog): actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_rd(input string req, input logic [AW-1:0] a);
        chk({req, " bus driven"}, DW'(rdata_oe), 32'd1);
        chk({req, " data"}, rdata, shadow[a]);
    endtask

    task automatic chk_off(input string req);
        chk({req, " bus released"}, DW'(rdata_oe), 32'd0);
    endtask

    task automatic idle();
        cs_n = 1'b0; cpu_n = 1'b1; ctl_n = 1'b1; adv_n = 1'b1;
        wall_n = 1'b1; wen_n = 1'b1; bsel_n = '1; wdata = '0;
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [AW-1:0] baddr(input logic [AW-1:0] b, input int n, input bit ilv);
        logic [1:0] off;
        off = ilv ? (b[1:0] ^ 2'(n)) : (b[1:0] + 2'(n));
        return {b[AW-1:2], off};
    endfunction

    function automatic logic [DW-1:0] pat(input int a);
        return 32'h1000_0000 + 32'(a) * 32'h0001_0203;
    endfunction

    task automatic t_reset();
        idle();
        rst_n = 1'b0;
        repeat (3) cyc();
        chk_off("R12 reset");
        rst_n = 1'b1;
        cyc();
        chk_off("R12 after reset");
    endtask

    // R7: fill with global writes while lane selects only cover two lanes
    task automatic t_preload();
        for (int a = 0; a < 64; a++) begin
            idle(); ctl_n = 1'b0; addr = AW'(a); wall_n = 1'b0;
            bsel_n = 4'b1010; wen_n = 1'b0; wdata = pat(a);
            cyc();
            shadow[a] = pat(a);
            chk_off("R10 write cycle");
        end
        idle(); cpu_n = 1'b0; addr = 6'd5; cyc();
        idle(); cyc();
        chk_rd("R7 global write all lanes", 6'd5);
    endtask

    task automatic t_burst(input bit ilv, input string req);
        for (int lo = 0; lo < 4; lo++) begin
            logic [AW-1:0] b;
            b = AW'(6'h14 + lo);
            idle(); cpu_n = 1'b0; addr = b; mode = ilv; cyc();
            for (int n = 1; n <= 4; n++) begin
                idle(); adv_n = 1'b0; cyc();
                chk_rd({req, " R9 beat"}, baddr(b, n - 1, ilv));
            end
            idle(); cyc();
            chk_rd("R5 wrap to start", b);
        end
        mode = 1'b0;
    endtask

    task automatic t_suspend();
        logic [AW-1:0] b;
        b = 6'h21;
        idle(); cpu_n = 1'b0; addr = b; cyc();
        idle(); adv_n = 1'b0; cyc(); chk_rd("R2 beat0", baddr(b, 0, 1'b0));
        idle(); cyc();               chk_rd("R2 beat1", baddr(b, 1, 1'b0));
        idle(); cyc();               chk_rd("R2 held", baddr(b, 1, 1'b0));
        idle(); adv_n = 1'b0; cyc(); chk_rd("R2 held again", baddr(b, 1, 1'b0));
        idle(); cyc();               chk_rd("R2 resumed", baddr(b, 2, 1'b0));
    endtask

    task automatic t_extend();
        logic [AW-1:0] a;
        logic [AW-1:0] b;
        a = 6'h0D; b = 6'h37;
        idle(); cpu_n = 1'b0; addr = a; cyc();
        idle(); adv_n = 1'b0; cyc(); chk_rd("R6 first beat", baddr(a, 0, 1'b0));
        idle(); adv_n = 1'b0; cyc(); chk_rd("R6 second beat", baddr(a, 1, 1'b0));
        idle(); ctl_n = 1'b0; addr = b; adv_n = 1'b0; cyc();
        chk_rd("R6 drain", baddr(a, 2, 1'b0));
        idle(); adv_n = 1'b0; cyc(); chk_rd("R6 new base", b);
        idle(); cyc();               chk_rd("R6 new beat1", baddr(b, 1, 1'b0));
    endtask

    task automatic t_byte_write();
        logic [AW-1:0] x;
        logic [DW-1:0] d;
        x = 6'h2A; d = 32'hDEAD_BEEF;
        idle(); ctl_n = 1'b0; addr = x; wen_n = 1'b0; bsel_n = 4'b0101; wdata = d; cyc();
        shadow[x] = {d[31:24], shadow[x][23:16], d[15:8], shadow[x][7:0]};
        chk_off("R10 during byte write");
        idle(); cyc(); chk_off("R10 stays released");
        idle(); cyc(); chk_off("R10 still released");
        // no write controls: a controller start reads
        idle(); ctl_n = 1'b0; addr = x; bsel_n = 4'b0000; wdata = 32'h0; cyc();
        idle(); cyc();
        chk_rd("R8 masked lanes", x);
    endtask

    task automatic t_cpu_ignores_write();
        idle(); cpu_n = 1'b0; addr = 6'h30; wall_n = 1'b0; wdata = 32'hFFFF_FFFF; cyc();
        idle(); cyc();
        chk_rd("R1 processor start ignores write", 6'h30);
        idle(); cpu_n = 1'b0; ctl_n = 1'b0; addr = 6'h31; wall_n = 1'b0; wdata = 32'h0; cyc();
        idle(); cyc();
        chk_rd("R1 processor strobe priority", 6'h31);
    endtask

    task automatic t_bus_off_on_write();
        logic [AW-1:0] z;
        logic [AW-1:0] w;
        z = 6'h08; w = baddr(z, 2, 1'b0);
        idle(); cpu_n = 1'b0; addr = z; cyc();
        idle(); adv_n = 1'b0; cyc(); chk_rd("R10 read before write", z);
        idle(); adv_n = 1'b0; wall_n = 1'b0; wdata = 32'hCAFE_0042; cyc();
        shadow[w] = 32'hCAFE_0042;
        chk_off("R10 write in burst");
        idle(); cyc(); chk_off("R10 no strobe after write");
        idle(); adv_n = 1'b0; cyc(); chk_off("R10 advance after write");
        idle(); cpu_n = 1'b0; addr = w; cyc();
        idle(); cyc();
        chk_rd("R10 strobe read reopens", w);
    endtask

    task automatic t_oe();
        idle(); cpu_n = 1'b0; addr = 6'h11; cyc();
        idle(); cyc();
        chk_rd("R11 enabled", 6'h11);
        oe_n = 1'b1; #0.5;
        chk_off("R11 output enable high");
        oe_n = 1'b0; #0.5;
        chk_rd("R11 re-enabled", 6'h11);
    endtask

    task automatic t_deselect();
        logic [AW-1:0] b;
        b = 6'h20;
        idle(); cpu_n = 1'b0; addr = b; cyc();
        idle(); adv_n = 1'b0; cyc(); chk_rd("R12 before deselect", b);
        idle(); cs_n = 1'b1; ctl_n = 1'b0; cyc();
        chk_rd("R12 pipeline drain", baddr(b, 1, 1'b0));
        idle(); adv_n = 1'b0; cyc(); chk_off("R12 deselected");
        idle(); adv_n = 1'b0; cyc(); chk_off("R12 advance ignored");
        idle(); cs_n = 1'b1; cpu_n = 1'b0; cyc();
        idle(); cyc(); chk_off("R12 processor strobe deselect");
    endtask

    initial begin
        t_reset();
        t_preload();
        t_burst(1'b0, "R3 linear");
        t_burst(1'b1, "R4 interleaved");
        t_suspend();
        t_extend();
        t_byte_write();
        t_cpu_ignores_write();
        t_bus_off_on_write();
        t_oe();
        t_deselect();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule